// File: doc/BRIEF.md
# Two-Word Command Port Decoder

This block sits behind the control port of a video controller. It takes two 16-bit writes in a row and builds from them a 16-bit access address and a 6-bit access code. The first word carries the low fourteen address bits and the two low code bits. The second word carries the two high address bits and the four high code bits. Between the two words a pending flag is held. The order is fixed: whatever arrives while the flag is set is taken as the second word.

When the second word completes a command, the block sends one pulse to the read-prefetch logic to clear its fetched and pending flags. If the code asks for DMA and DMA is enabled, it also raises a DMA start pulse. Any data-port access or status read that arrives while a command is half-written drops the pending flag. A data-port access also clears the prefetch state. A first word whose two top bits mark a register write is reported as such and leaves the command state alone. The block also decodes which memory the current code targets and whether it is a write, and it forms the status word returned on a control-port read.

Top module: `cmd_port_decoder`

## Requirements
- R1: A control write while not pending, whose top two bits are not binary 10, loads address bits 13:0 from word bits 13:0 and code bits 1:0 from word bits 15:14. It leaves address bits 15:14 and code bits 5:2 unchanged and sets the pending flag. The results are visible in the next cycle.
- R2: A control write while pending loads address bits 15:14 from word bits 1:0 and code bits 5:2 from word bits 7:4, whatever its top bits are, and clears the pending flag.
- R3: Completing a command with the second word gives a one-cycle pulse on `pf_clear` in the next cycle.
- R4: `dma_start` pulses for one cycle after the second word when the new code bit 5 (word bit 7) is 1 and `dma_en` is 1. It stays low otherwise.
- R5: A data-port access while pending clears the pending flag and pulses `pf_clear`. The same access while not pending produces no pulse. Address and code are left unchanged in both cases.
- R6: A status read clears the pending flag without pulsing `pf_clear`. `status_rdata` has bit 9 equal to `fifo_empty` and all other bits, including 15:10, equal to 0.
- R7: `acc_target` decodes code bits 3:0 as follows: 0 or 1 gives 0 (video RAM), 4 or 5 gives 1 (scroll RAM), 8 gives 2 (colour RAM), and any other value gives 3. `acc_write` equals code bit 0.
- R8: A control write while not pending whose top two bits are binary 10 pulses `reg_wr` for one cycle. It leaves pending, address and code unchanged.
- R9: After synchronous active-low reset, pending, address, code and all pulse outputs are 0.
- R10: A control write in the same cycle as a data access or status read takes precedence over them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_wr | input | 1 | Control-port write strobe |
| ctrl_wdata | input | 16 | Control-port write word |
| ctrl_rd | input | 1 | Control-port (status) read strobe |
| data_acc | input | 1 | Data-port read or write strobe |
| dma_en | input | 1 | DMA enable bit from the mode register |
| fifo_empty | input | 1 | Write FIFO is empty |
| cmd_pending | output | 1 | First word held, second awaited |
| acc_addr | output | 16 | Current access address |
| acc_code | output | 6 | Current access code |
| acc_target | output | 2 | Decoded target memory |
| acc_write | output | 1 | Code denotes a write |
| pf_clear | output | 1 | Pulse: clear read-prefetch flags |
| dma_start | output | 1 | Pulse: start DMA |
| reg_wr | output | 1 | Pulse: register write detected |
| status_rdata | output | 16 | Status word for control-port reads |

## Verification
The bench builds the block with its default parameters: a 16-bit word, a 14-bit low address field, a 6-bit code with its high part at word bits 7:4, and the FIFO-empty flag at status bit 9. With these values, every split of address and code across the two words falls on real bit positions. The vectors drive all-ones and mixed patterns through both halves. They exercise code bit 5 with DMA both enabled and disabled, and every class of target decode. The directed tests cover cancellation of a half-written command, the register-write marker, and simultaneous strobes.

// File: rtl/cmdp_pkg.sv
// Package: shared types for the command port decoder.
// Assumes: nothing; holds the target-memory encoding only.
package cmdp_pkg;
    typedef enum logic [1:0] {
        TGT_VIDEO  = 2'd0,
        TGT_SCROLL = 2'd1,
        TGT_COLOUR = 2'd2,
        TGT_OTHER  = 2'd3
    } target_e;
endpackage

// File: rtl/cmdp_cmd_regs.sv
// Module: cmdp_cmd_regs
// Holds address, code and the pending flag built from two control words,
// and produces the completion, DMA-start and register-write pulses.
// Assumes: CODE_LO_W == 2 (register-write marker is binary 10 in the top
// bits); a control write has priority over data access and status read.
module cmdp_cmd_regs #(
    parameter int WORD_W      = 16,
    parameter int ADDR_W      = 16,
    parameter int CODE_W      = 6,
    parameter int LO_BITS     = 14,
    parameter int CODE_HI_POS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic [WORD_W-1:0] ctrl_wdata,
    input  logic              ctrl_rd,
    input  logic              data_acc,
    input  logic              dma_en,
    output logic              pending,
    output logic [ADDR_W-1:0] addr,
    output logic [CODE_W-1:0] code,
    output logic              pf_clear,
    output logic              dma_start,
    output logic              reg_wr
);
    localparam int HI_BITS   = ADDR_W - LO_BITS;
    localparam int CODE_LO_W = WORD_W - LO_BITS;
    localparam int CODE_HI_W = CODE_W - CODE_LO_W;
    localparam logic [CODE_LO_W-1:0] REG_MARK = {1'b1, {(CODE_LO_W-1){1'b0}}};

    logic [CODE_LO_W-1:0] top_bits;
    logic                 first_ok;
    logic                 second_ok;
    logic                 cancel;
    logic [CODE_HI_W-1:0] code_hi_new;

    // Classify the incoming control word and the cancel sources.
    always_comb begin
        top_bits    = ctrl_wdata[WORD_W-1 -: CODE_LO_W];
        first_ok    = ctrl_wr && !pending && (top_bits != REG_MARK);
        second_ok   = ctrl_wr && pending;
        cancel      = !ctrl_wr && (data_acc || ctrl_rd);
        code_hi_new = ctrl_wdata[CODE_HI_POS +: CODE_HI_W];
    end

    // Address and code fields: low half from the first word, high from the second.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr <= '0;
            code <= '0;
        end else if (first_ok) begin
            addr[LO_BITS-1:0]   <= ctrl_wdata[LO_BITS-1:0];
            code[CODE_LO_W-1:0] <= top_bits;
        end else if (second_ok) begin
            addr[ADDR_W-1 -: HI_BITS]  <= ctrl_wdata[HI_BITS-1:0];
            code[CODE_W-1 -: CODE_HI_W] <= code_hi_new;
        end
    end

    // Pending flag: set by the first word, dropped by the second or a cancel.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pending <= 1'b0;
        else if (first_ok)
            pending <= 1'b1;
        else if (second_ok || cancel)
            pending <= 1'b0;
    end

    // One-cycle pulses for prefetch clear, DMA start and register write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pf_clear  <= 1'b0;
            dma_start <= 1'b0;
            reg_wr    <= 1'b0;
        end else begin
            pf_clear  <= second_ok || (pending && !ctrl_wr && data_acc);
            dma_start <= second_ok && dma_en && code_hi_new[CODE_HI_W-1];
            reg_wr    <= ctrl_wr && !pending && (top_bits == REG_MARK);
        end
    end

    // R1: a plain first word sets pending
    p_first_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && !pending && top_bits != REG_MARK) |=> pending);

    // R2 / R3: a second word completes the command and clears prefetch
    p_second_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && pending) |=> (!pending && pf_clear));

    // R4: DMA start only follows a completing second word with DMA enabled
    p_dma_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dma_start |-> ($past(ctrl_wr) && $past(pending) && $past(dma_en)));

    // R5: data access while pending cancels and clears prefetch
    p_data_cancel_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (data_acc && pending && !ctrl_wr) |=> (!pending && pf_clear && $stable(addr)));

    // R6: status read cancels pending
    p_rd_cancel_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_rd && !ctrl_wr) |=> !pending);

    // R8: register write leaves command state untouched
    p_regwr_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && !pending && top_bits == REG_MARK) |=>
            (reg_wr && !pending && $stable(addr) && $stable(code)));
endmodule

// File: rtl/cmdp_kind_decode.sv
// Module: cmdp_kind_decode
// Maps the low code nibble to a target memory and a write direction.
// Assumes: CODE_W >= 4; bit 0 of the code is the direction.
module cmdp_kind_decode #(
    parameter int CODE_W = 6
) (
    input  logic [CODE_W-1:0]      code,
    output cmdp_pkg::target_e      target,
    output logic                   is_write
);
    import cmdp_pkg::*;

    // Decode target memory from code bits 3:0.
    always_comb begin
        is_write = code[0];
        unique case (code[3:0])
            4'h0, 4'h1: target = TGT_VIDEO;
            4'h4, 4'h5: target = TGT_SCROLL;
            4'h8:       target = TGT_COLOUR;
            default:    target = TGT_OTHER;
        endcase
    end

    // R7: a write code never decodes to the colour target
    always_comb begin
        if (code[0]) assert (target != TGT_COLOUR);
    end
endmodule

// File: rtl/cmdp_status.sv
// Module: cmdp_status
// Forms the status word returned on a control-port read.
// Assumes: only the FIFO-empty flag is reported; all other bits read 0.
module cmdp_status #(
    parameter int WORD_W    = 16,
    parameter int EMPTY_BIT = 9
) (
    input  logic              fifo_empty,
    output logic [WORD_W-1:0] status
);
    // Place the FIFO-empty flag at its bit, zero elsewhere.
    always_comb begin
        status            = '0;
        status[EMPTY_BIT] = fifo_empty;
    end
endmodule

// File: rtl/cmd_port_decoder.sv
// Module: cmd_port_decoder (top)
// Decodes two-word control-port commands into address and code, tracks the
// half-written state, and forms status and target decode.
// Assumes: strobes are single-cycle; synchronous active-low reset.
module cmd_port_decoder #(
    parameter int WORD_W      = 16,
    parameter int ADDR_W      = 16,
    parameter int CODE_W      = 6,
    parameter int LO_BITS     = 14,
    parameter int CODE_HI_POS = 4,
    parameter int EMPTY_BIT   = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic [WORD_W-1:0] ctrl_wdata,
    input  logic              ctrl_rd,
    input  logic              data_acc,
    input  logic              dma_en,
    input  logic              fifo_empty,
    output logic              cmd_pending,
    output logic [ADDR_W-1:0] acc_addr,
    output logic [CODE_W-1:0] acc_code,
    output logic [1:0]        acc_target,
    output logic              acc_write,
    output logic              pf_clear,
    output logic              dma_start,
    output logic              reg_wr,
    output logic [WORD_W-1:0] status_rdata
);
    cmdp_pkg::target_e tgt;

    cmdp_cmd_regs #(
        .WORD_W(WORD_W), .ADDR_W(ADDR_W), .CODE_W(CODE_W),
        .LO_BITS(LO_BITS), .CODE_HI_POS(CODE_HI_POS)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
        .ctrl_rd(ctrl_rd), .data_acc(data_acc), .dma_en(dma_en),
        .pending(cmd_pending), .addr(acc_addr), .code(acc_code),
        .pf_clear(pf_clear), .dma_start(dma_start), .reg_wr(reg_wr)
    );

    cmdp_kind_decode #(.CODE_W(CODE_W)) u_kind (
        .code(acc_code), .target(tgt), .is_write(acc_write)
    );

    cmdp_status #(.WORD_W(WORD_W), .EMPTY_BIT(EMPTY_BIT)) u_stat (
        .fifo_empty(fifo_empty), .status(status_rdata)
    );

    assign acc_target = tgt;
endmodule

// File: tb/test_cmd_port_decoder.sv
module test_cmd_port_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctrl_wr = 1'b0;
    logic [15:0] ctrl_wdata = '0;
    logic        ctrl_rd = 1'b0;
    logic        data_acc = 1'b0;
    logic        dma_en = 1'b0;
    logic        fifo_empty = 1'b0;
    logic        cmd_pending;
    logic [15:0] acc_addr;
    logic [5:0]  acc_code;
    logic [1:0]  acc_target;
    logic        acc_write;
    logic        pf_clear;
    logic        dma_start;
    logic        reg_wr;
    logic [15:0] status_rdata;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    cmd_port_decoder i_cmd_port_decoder (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
        .ctrl_rd(ctrl_rd), .data_acc(data_acc), .dma_en(dma_en),
        .fifo_empty(fifo_empty), .cmd_pending(cmd_pending), .acc_addr(acc_addr),
        .acc_code(acc_code), .acc_target(acc_target), .acc_write(acc_write),
        .pf_clear(pf_clear), .dma_start(dma_start), .reg_wr(reg_wr),
        .status_rdata(status_rdata)
    );

    typedef struct packed {
        logic [15:0] w1;
        logic [15:0] w2;
        logic        den;
        logic [15:0] addr;
        logic [5:0]  code;
        logic        dma;
        logic [1:0]  tgt;
        logic        wr;
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{16'h4000, 16'h0000, 1'b0, 16'h0000, 6'h01, 1'b0, 2'd0, 1'b1},
        '{16'h0000, 16'h0010, 1'b0, 16'h0000, 6'h04, 1'b0, 2'd1, 1'b0},
        '{16'h3FFF, 16'h0023, 1'b1, 16'hFFFF, 6'h08, 1'b0, 2'd2, 1'b0},
        '{16'h4ABC, 16'h0081, 1'b1, 16'h4ABC, 6'h21, 1'b1, 2'd0, 1'b1},
        '{16'h4ABC, 16'h0081, 1'b0, 16'h4ABC, 6'h21, 1'b0, 2'd0, 1'b1},
        '{16'hC123, 16'h0042, 1'b0, 16'h8123, 6'h13, 1'b0, 2'd3, 1'b1},
        '{16'h4005, 16'h00F0, 1'b1, 16'h0005, 6'h3D, 1'b1, 2'd3, 1'b1}
    };

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // One-cycle control write; returns at the next falling edge.
    task automatic wr_ctrl(input logic [15:0] w);
        ctrl_wr    = 1'b1;
        ctrl_wdata = w;
        @(negedge clk);
        ctrl_wr    = 1'b0;
    endtask

    task automatic strobe_data();
        data_acc = 1'b1;
        @(negedge clk);
        data_acc = 1'b0;
    endtask

    task automatic strobe_rd();
        ctrl_rd = 1'b1;
        @(negedge clk);
        ctrl_rd = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        chk("R9", "pending", cmd_pending, 0);
        chk("R9", "addr", acc_addr, 0);
        chk("R9", "code", acc_code, 0);
        chk("R9", "pulses", {pf_clear, dma_start, reg_wr}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Vector table: R1 R2 R3 R4 R7
        for (int i = 0; i < 7; i++) begin
            dma_en = VECS[i].den;
            wr_ctrl(VECS[i].w1);
            chk("R1", "pending after first", cmd_pending, 1);
            chk("R1", "addr low", acc_addr[13:0], VECS[i].addr[13:0]);
            chk("R1", "code low", acc_code[1:0], VECS[i].code[1:0]);
            wr_ctrl(VECS[i].w2);
            chk("R2", "pending after second", cmd_pending, 0);
            chk("R2", "addr", acc_addr, VECS[i].addr);
            chk("R2", "code", acc_code, VECS[i].code);
            chk("R3", "pf_clear", pf_clear, 1);
            chk("R4", "dma_start", dma_start, VECS[i].dma);
            chk("R7", "target", acc_target, VECS[i].tgt);
            chk("R7", "write", acc_write, VECS[i].wr);
            @(negedge clk);
            chk("R3", "pf_clear one cycle", pf_clear, 0);
            chk("R4", "dma_start one cycle", dma_start, 0);
        end
        dma_en = 1'b0;

        // R8: register write marker (state: addr 0005, code 3D)
        wr_ctrl(16'h8123);
        chk("R8", "reg_wr", reg_wr, 1);
        chk("R8", "pending", cmd_pending, 0);
        chk("R8", "addr", acc_addr, 16'h0005);
        chk("R8", "code", acc_code, 6'h3D);
        @(negedge clk);
        chk("R8", "reg_wr one cycle", reg_wr, 0);

        // R5: data access cancels a half command
        wr_ctrl(16'h0123);
        chk("R1", "high bits kept", {acc_addr, 10'h0, acc_code}, {16'h0123, 10'h0, 6'h3C});
        strobe_data();
        chk("R5", "pending", cmd_pending, 0);
        chk("R5", "pf_clear", pf_clear, 1);
        chk("R5", "addr", acc_addr, 16'h0123);
        @(negedge clk);
        strobe_data();
        chk("R5", "no pf_clear idle", pf_clear, 0);
        chk("R5", "addr idle", acc_addr, 16'h0123);

        // R6: status read cancels pending, no prefetch clear
        wr_ctrl(16'h4000);
        chk("R6", "pending set", cmd_pending, 1);
        strobe_rd();
        chk("R6", "pending", cmd_pending, 0);
        chk("R6", "pf_clear", pf_clear, 0);
        fifo_empty = 1'b1;
        #1;
        chk("R6", "status empty", status_rdata, 16'h0200);
        fifo_empty = 1'b0;
        #1;
        chk("R6", "status busy", status_rdata, 16'h0000);
        @(negedge clk);

        // R10: control write wins over a simultaneous data access
        wr_ctrl(16'h0000);
        ctrl_wr = 1'b1; ctrl_wdata = 16'h0002; data_acc = 1'b1; ctrl_rd = 1'b1;
        @(negedge clk);
        ctrl_wr = 1'b0; data_acc = 1'b0; ctrl_rd = 1'b0;
        chk("R10", "addr", acc_addr, 16'h8000);
        chk("R10", "code", acc_code, 6'h00);
        chk("R10", "pending", cmd_pending, 0);

        // R9: reset mid command
        wr_ctrl(16'h7FFF);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R9", "pending after reset", cmd_pending, 0);
        chk("R9", "addr after reset", acc_addr, 0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule